// File: doc/BRIEF.md
# I2C Master SCL Rate Divider

This block sets the SCL timing of an I2C master. It holds a 7-bit down-counter that is loaded from the low seven bits of a baud control register. It counts on phase ticks, of which the clocking logic delivers two per instruction cycle. A write to the transmit data buffer loads the counter and starts it. The counter then runs down to zero. The next tick after that produces a one-cycle rollover pulse and toggles the SCL level. The counter then parks until the master sequencer asks for a reload.

Each rollover marks one half of an SCL period. One SCL period therefore takes `2*(reload+1)` ticks, which gives an SCL rate of the instruction rate divided by `reload+1`. When the sequencer reports that the last data bit and its acknowledge are done, the counter stops and SCL keeps its current level. Two instances share only the clock and can run at the same time, each at its own rate.

Top module: `i2c_scl_div`

## Requirements
- R1: While reset is asserted and right after it, `scl_o` is 1 and `rollover_o` is 0.
- R2: Only bits 6:0 of `baud_reg_i` set the load value. Bit 7 has no effect on timing, so 0x83 behaves exactly like 0x03.
- R3: Before the first buffer write, ticks cause no rollover and `scl_o` stays 1.
- R4: After a load with value N, the (N+1)-th tick that follows gives a rollover. Ticks before it give none, and cycles without a tick do not count.
- R5: After a rollover with no reload request, the counter stays parked: further ticks give no rollover.
- R6: A reload request while running reloads the counter and starts a fresh N+1 tick half period. A tick in the same clock as a reload request is ignored.
- R7: `scl_o` inverts in exactly the cycle in which `rollover_o` is 1 and is stable otherwise. A full SCL period spans two rollovers.
- R8: After `xfer_done_i`, ticks and reload requests give no rollover and `scl_o` holds its level until the next buffer write restarts counting.
- R9: A load value of 0 gives a rollover on the first tick after the load.
- R10: Two instances with different load values run independently from the same ticks.
- R11: `rollover_o` is a single-cycle pulse, registered one clock after the decisive tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_reg_i | input | 8 | Baud control register; bits 6:0 form the load value |
| tick_i | input | 1 | Phase tick, two per instruction cycle |
| buf_wr_i | input | 1 | Transmit buffer write strobe: load and start |
| reload_req_i | input | 1 | Reload request from the master sequencer |
| xfer_done_i | input | 1 | Last bit and acknowledge complete: stop counting |
| rollover_o | output | 1 | One-cycle pulse at the end of each half period |
| scl_o | output | 1 | SCL level, idle high |

## Verification
The bench counts the ticks to each rollover for the load values 0, 2 and 3, with and without idle cycles between ticks. An off-by-one count would shift the pulse one tick early or late. It also issues a reload together with a tick, which a design that let the tick through would finish one tick early. Keeping the register's top bit set shows whether bit 7 leaks into the count, since that would stretch the half period by 128 ticks. A parked counter and a stopped transfer are fed further ticks and reload requests, which would show up as spurious rollovers or a moving SCL. A second instance with a different load, started in the same cycle, has to roll over at its own tick count.

// File: rtl/i2c_scl_div_pkg.sv
package i2c_scl_div_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_START,
    CMD_STOP,
    CMD_RELOAD,
    CMD_STEP
  } brg_cmd_e;
endpackage

// File: rtl/brg_cmd_decode.sv
module brg_cmd_decode
  import i2c_scl_div_pkg::*;
(
  input  logic     buf_wr_i,
  input  logic     xfer_done_i,
  input  logic     reload_req_i,
  input  logic     tick_i,
  input  logic     running_i,
  output brg_cmd_e cmd_o
);
  // priority: buffer write > stop > reload > tick
  always_comb begin
    if (buf_wr_i)                       cmd_o = CMD_START;
    else if (xfer_done_i)               cmd_o = CMD_STOP;
    else if (reload_req_i && running_i) cmd_o = CMD_RELOAD;
    else if (tick_i && running_i)       cmd_o = CMD_STEP;
    else                                cmd_o = CMD_IDLE;
  end
endmodule

// File: rtl/brg_down_counter.sv
module brg_down_counter
  import i2c_scl_div_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  brg_cmd_e         cmd_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             roll_set_o,
  output logic             roll_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, running_q, roll_q;

  // terminal tick: counter already at zero and still armed
  assign roll_set_o = (cmd_i == CMD_STEP) && armed_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      running_q <= 1'b0;
      roll_q    <= 1'b0;
    end else begin
      roll_q <= roll_set_o;
      unique case (cmd_i)
        CMD_START: begin
          cnt_q     <= load_i;
          armed_q   <= 1'b1;
          running_q <= 1'b1;
        end
        CMD_STOP: begin
          armed_q   <= 1'b0;
          running_q <= 1'b0;
        end
        CMD_RELOAD: begin
          cnt_q   <= load_i;
          armed_q <= 1'b1;
        end
        CMD_STEP: begin
          if (armed_q) begin
            if (cnt_q == '0) armed_q <= 1'b0;
            else             cnt_q   <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = running_q;
  assign roll_o    = roll_q;
endmodule

// File: rtl/brg_scl_gen.sv
module brg_scl_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic roll_set_i,
  output logic scl_o
);
  logic scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         scl_q <= 1'b1;
    else if (roll_set_i) scl_q <= ~scl_q;
  end

  assign scl_o = scl_q;
endmodule

// File: rtl/i2c_scl_div.sv
module i2c_scl_div
  import i2c_scl_div_pkg::*;
#(
  parameter int unsigned REG_W = 8,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] baud_reg_i,
  input  logic             tick_i,
  input  logic             buf_wr_i,
  input  logic             reload_req_i,
  input  logic             xfer_done_i,
  output logic             rollover_o,
  output logic             scl_o
);
  localparam logic [REG_W-1:0] LOAD_MASK = REG_W'((1 << CNT_W) - 1);

  brg_cmd_e         cmd_w;
  logic [CNT_W-1:0] load_w, cnt_w;
  logic             running_w, roll_set_w;

  assign load_w = CNT_W'(baud_reg_i & LOAD_MASK);

  brg_cmd_decode u_dec (
    .buf_wr_i     (buf_wr_i),
    .xfer_done_i  (xfer_done_i),
    .reload_req_i (reload_req_i),
    .tick_i       (tick_i),
    .running_i    (running_w),
    .cmd_o        (cmd_w)
  );

  brg_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_w),
    .load_i     (load_w),
    .cnt_o      (cnt_w),
    .running_o  (running_w),
    .roll_set_o (roll_set_w),
    .roll_o     (rollover_o)
  );

  brg_scl_gen u_scl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .roll_set_i (roll_set_w),
    .scl_o      (scl_o)
  );
endmodule

// File: rtl/i2c_scl_div_chk.sv
module i2c_scl_div_chk #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] baud_reg_i,
  input logic             tick_i,
  input logic             buf_wr_i,
  input logic             reload_req_i,
  input logic             xfer_done_i,
  input logic             running_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             rollover_o,
  input logic             scl_o
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (scl_o && !rollover_o));

  assert_load_low_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_i |=> cnt_i == $past(baud_reg_i[CNT_W-1:0]));

  assert_idle_no_roll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_i && !buf_wr_i) |=> !rollover_o);

  assert_reload_tick_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_req_i && running_i && !buf_wr_i && !xfer_done_i && tick_i) |=> !rollover_o);

  assert_scl_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollover_o |-> scl_o != $past(scl_o));

  assert_scl_steady_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rollover_o |-> $stable(scl_o));

  assert_stop_no_roll_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && !buf_wr_i) |=> !rollover_o);

  assert_single_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollover_o |=> !rollover_o);

  assert_roll_needs_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !rollover_o);
endmodule

bind i2c_scl_div i2c_scl_div_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .baud_reg_i   (baud_reg_i),
  .tick_i       (tick_i),
  .buf_wr_i     (buf_wr_i),
  .reload_req_i (reload_req_i),
  .xfer_done_i  (xfer_done_i),
  .running_i    (running_w),
  .cnt_i        (cnt_w),
  .rollover_o   (rollover_o),
  .scl_o        (scl_o)
);

// File: tb/tb_i2c_scl_div.sv
module tb_i2c_scl_div;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit    ra;
    bit    sa;
    bit    rb;
    bit    sb;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_a = 8'h00, reg_b = 8'h00;
  logic       tick = 1'b0, wr_a = 1'b0, wr_b = 1'b0, rl = 1'b0, dn = 1'b0;
  logic       roll_a, scl_a, roll_b, scl_b;

  int   n_chk = 0, n_err = 0;
  bit   exp_scl_a = 1'b1, exp_scl_b = 1'b1;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_div dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_reg_i(reg_a), .tick_i(tick),
    .buf_wr_i(wr_a), .reload_req_i(rl), .xfer_done_i(dn),
    .rollover_o(roll_a), .scl_o(scl_a)
  );

  // second instance for R10: shares clock and ticks only
  i2c_scl_div dut_b (
    .clk_i(clk), .rst_ni(rst_n), .baud_reg_i(reg_b), .tick_i(tick),
    .buf_wr_i(wr_b), .reload_req_i(1'b0), .xfer_done_i(1'b0),
    .rollover_o(roll_b), .scl_o(scl_b)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: compare each queued expectation a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.req, "rollover_a", int'(roll_a), int'(e.ra));
      check(e.req, "scl_a",      int'(scl_a),  int'(e.sa));
      check(e.req, "rollover_b", int'(roll_b), int'(e.rb));
      check(e.req, "scl_b",      int'(scl_b),  int'(e.sb));
    end
  end

  // driver: one clock of stimulus plus the result expected after that edge
  task automatic step(bit tk, bit w, bit wb, bit r, bit d, bit ea, bit eb, string req);
    exp_t e;
    @(negedge clk);
    tick = tk; wr_a = w; wr_b = wb; rl = r; dn = d;
    if (ea) exp_scl_a = ~exp_scl_a;
    if (eb) exp_scl_b = ~exp_scl_b;
    e.ra = ea; e.sa = exp_scl_a; e.rb = eb; e.sb = exp_scl_b; e.req = req;
    sb_q.push_back(e);
  endtask

  // load (start or reload) then N+1 ticks, the last one rolling over
  task automatic half(logic [7:0] r, bit start, bit tick_on_load, bit gaps, string req);
    int n;
    reg_a = r;
    n = int'(r[6:0]) + 1;
    step(tick_on_load, start, 1'b0, !start, 1'b0, 1'b0, 1'b0, req);
    for (int k = 1; k <= n; k++) begin
      if (gaps) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, k == n, 1'b0, req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD*2);
    check("R1", "scl in reset", int'(scl_a), 1);
    check("R1", "rollover in reset", int'(roll_a), 0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

    // R3: ticks before any buffer write
    reg_a = 8'h00;
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");

    // R4/R7: start with 3, four ticks to rollover
    half(8'h03, 1'b1, 1'b0, 1'b0, "R4");
    // R6: reload with coincident tick, still four ticks
    half(8'h03, 1'b0, 1'b1, 1'b0, "R6");
    // R5: parked, no reload
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    // R2: bit 7 set, same timing as 3
    half(8'h83, 1'b0, 1'b0, 1'b0, "R2");
    // R4: idle cycles between ticks do not count
    half(8'h02, 1'b0, 1'b0, 1'b1, "R4");
    // R9: zero load rolls on first tick, twice
    half(8'h00, 1'b0, 1'b0, 1'b0, "R9");
    half(8'h00, 1'b0, 1'b0, 1'b0, "R9");

    // R8: stop mid-count; ticks and reloads then do nothing
    reg_a = 8'h05;
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    // restart by buffer write
    half(8'h01, 1'b1, 1'b0, 1'b0, "R8");

    // R10: two instances started together, loads 2 and 5
    reg_a = 8'h02; reg_b = 8'h05;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    for (int k = 1; k <= 8; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, k == 3, k == 6, "R10");
    // R11: one more idle cycle confirms pulses ended
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11");

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule